// File: doc/BRIEF.md
# Slave-Mode Controlled Up-Counter Timer

A 16-bit up-counting timer built from a prescaler, a reload register and a slave-mode controller. Software sets it up through a simple single-cycle register write port. The slave-mode controller chooses how one external trigger line acts on the counter. It can restart the count, gate it, start it once, or act as the count clock. The trigger line is chosen from a small set of sources by an index field.

Each update event sets a status flag and can raise an interrupt request. The update events are a counter wrap, a forced update and a trigger-driven restart. A master-mode field picks which internal event is sent out on a trigger output, so that neighbouring timers or converters can follow this one.

Top module: `slave_timer`

## Requirements
- R1: After reset the counter, status flag, interrupt request and trigger output are 0. The prescaler and active prescaler are 0, and the reload value is all ones.
- R2: The count advances once for every P+1 qualified ticks, where P is the active prescaler value written at address 2. On reaching the active reload value (address 3), the next advance returns the count to 0 and produces an update event.
- R3: Each update event sets the status flag (bit 0 of address 4). Writing address 4 with bit 0 = 0 clears the flag, but an update in the same cycle wins. The interrupt request is high while the flag and the interrupt enable (address 0 bit 2) are both set.
- R4: A write to address 5 with bit 0 = 1 forces an update: the counter and prescaler counter clear, and the buffered values load. The prescaler value always takes effect only at an update. The reload value is also buffered while preload enable (address 0 bit 1) is set; otherwise it takes effect at once.
- R5: With the slave-mode field (address 1 bits 2:0) at 4, a rising edge of the selected trigger clears the count and produces an update event. A level change on a trigger source reaches the controller two clock edges after it is sampled.
- R6: Slave mode 5 counts only while the selected trigger is high. A low trigger holds the count without clearing it.
- R7: Slave mode 6 sets the count enable (address 0 bit 0) on a rising edge of the selected trigger without clearing the count. A falling edge does not stop counting.
- R8: Slave mode 7 advances the count once per rising edge of the selected trigger, while the count enable is set.
- R9: Address 1 bits 9:8 select the trigger source. Edges on sources that are not selected have no effect.
- R10: The master-mode field (address 1 bits 6:4) drives the trigger output, registered, as follows. Code 2 gives a one-cycle pulse on every update event. Code 0 gives a pulse only on a forced or trigger-driven update. Code 1 follows the count enable. All other codes keep the output low.
- R11: Slave-mode codes 1, 2 and 3 are reserved: in them the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | CNT_W | Register write data |
| trig_i | input | N_TRIG | Candidate trigger sources |
| cnt_o | output | CNT_W | Current count |
| upd_flag_o | output | 1 | Update status flag |
| irq_o | output | 1 | Interrupt request |
| trg_o | output | 1 | Trigger output for other blocks |

## Verification
The status flag can receive a set and a software clear in the same cycle. The bench provokes this in slave mode 4. Because the synchronizer delay is fixed at two edges, the bench can time a status-clear write to land on the exact edge at which the trigger-driven restart fires. It judges the result by the flag still being 1 and the count being 0 after that edge. A clocked property also checks that every update event is followed by a set flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [2:0] SM_OFF    = 3'd0;
  localparam logic [2:0] SM_RESET  = 3'd4;
  localparam logic [2:0] SM_GATED  = 3'd5;
  localparam logic [2:0] SM_START  = 3'd6;
  localparam logic [2:0] SM_EXTCLK = 3'd7;

  localparam logic [2:0] MM_RSTUPD = 3'd0;
  localparam logic [2:0] MM_ENABLE = 3'd1;
  localparam logic [2:0] MM_UPDATE = 3'd2;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_MODE   = 3'd1;
  localparam logic [2:0] A_PSC    = 3'd2;
  localparam logic [2:0] A_RELOAD = 3'd3;
  localparam logic [2:0] A_STATUS = 3'd4;
  localparam logic [2:0] A_CMD    = 3'd5;

  typedef struct packed {
    logic irq_en;
    logic pre_en;
    logic cnt_en;
  } ctrl_t;
endpackage

// File: rtl/tmr_trig_in.sv
module tmr_trig_in #(
  parameter int N_TRIG = 4,
  parameter int SEL_W  = 2,
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TRIG-1:0] src_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              level_o,
  output logic              rise_o
);
  logic              pick;
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;

  always_comb begin
    pick = 1'b0;
    for (int i = 0; i < N_TRIG; i++)
      if (SEL_W'(i) == sel_i) pick = src_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], pick};
      prev_q <= sync_q[SYNC_N-1];
    end
  end

  assign level_o = sync_q[SYNC_N-1];
  assign rise_o  = sync_q[SYNC_N-1] & ~prev_q;
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] psc_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] div_q, cnt_q;
  logic             adv;

  assign adv    = tick_i && (div_q == psc_i);
  assign wrap_o = !clear_i && adv && (cnt_q == reload_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (tick_i) begin
      if (adv) begin
        div_q <= '0;
        cnt_q <= (cnt_q == reload_i) ? '0 : cnt_q + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/slave_timer.sv
module slave_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_TRIG = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [N_TRIG-1:0] trig_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              upd_flag_o,
  output logic              irq_o,
  output logic              trg_o
);
  localparam int SEL_W = (N_TRIG > 1) ? $clog2(N_TRIG) : 1;
  localparam int SEL_LSB = 8;

  ctrl_t            ctrl_q;
  logic [2:0]       sm_q, mm_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] psc_q, psc_act_q, arr_q, arr_sh_q, arr_eff;
  logic             flag_q, trg_q;
  logic             trig_level, trig_rise;
  logic             wr_ctrl, wr_mode, wr_status, force_upd, slave_rst;
  logic             upd_req, upd_ev, wrap, tick;

  assign wr_ctrl   = wr_en_i && (wr_addr_i == A_CTRL);
  assign wr_mode   = wr_en_i && (wr_addr_i == A_MODE);
  assign wr_status = wr_en_i && (wr_addr_i == A_STATUS);
  assign force_upd = wr_en_i && (wr_addr_i == A_CMD) && wr_data_i[0];

  tmr_trig_in #(.N_TRIG(N_TRIG), .SEL_W(SEL_W), .SYNC_N(2)) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (trig_i),
    .sel_i  (sel_q),
    .level_o(trig_level),
    .rise_o (trig_rise)
  );

  assign slave_rst = (sm_q == SM_RESET) && trig_rise;
  assign upd_req   = force_upd || slave_rst;
  assign upd_ev    = upd_req || wrap;
  assign arr_eff   = ctrl_q.pre_en ? arr_sh_q : arr_q;

  always_comb begin
    unique case (sm_q)
      SM_OFF, SM_RESET, SM_START: tick = ctrl_q.cnt_en;
      SM_GATED:                   tick = ctrl_q.cnt_en && trig_level;
      SM_EXTCLK:                  tick = ctrl_q.cnt_en && trig_rise;
      default:                    tick = 1'b0;
    endcase
  end

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .clear_i (upd_req),
    .psc_i   (psc_act_q),
    .reload_i(arr_eff),
    .cnt_o   (cnt_o),
    .wrap_o  (wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      sm_q   <= SM_OFF;
      mm_q   <= MM_RSTUPD;
      sel_q  <= '0;
      psc_q  <= '0;
      arr_q  <= '1;
    end else begin
      if (wr_ctrl)
        ctrl_q <= ctrl_t'(wr_data_i[2:0]);
      else if ((sm_q == SM_START) && trig_rise)
        ctrl_q.cnt_en <= 1'b1;
      if (wr_mode) begin
        sm_q  <= wr_data_i[2:0];
        mm_q  <= wr_data_i[6:4];
        sel_q <= wr_data_i[SEL_LSB +: SEL_W];
      end
      if (wr_en_i && (wr_addr_i == A_PSC))    psc_q <= wr_data_i;
      if (wr_en_i && (wr_addr_i == A_RELOAD)) arr_q <= wr_data_i;
    end
  end

  // buffered copies: prescaler always, reload only while preload is on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_act_q <= '0;
      arr_sh_q  <= '1;
    end else begin
      if (upd_ev) psc_act_q <= psc_q;
      if (upd_ev || !ctrl_q.pre_en) arr_sh_q <= arr_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      trg_q  <= 1'b0;
    end else begin
      if (upd_ev)                         flag_q <= 1'b1;
      else if (wr_status && !wr_data_i[0]) flag_q <= 1'b0;
      unique case (mm_q)
        MM_RSTUPD: trg_q <= upd_req;
        MM_ENABLE: trg_q <= ctrl_q.cnt_en;
        MM_UPDATE: trg_q <= upd_ev;
        default:   trg_q <= 1'b0;
      endcase
    end
  end

  assign upd_flag_o = flag_q;
  assign irq_o      = flag_q && ctrl_q.irq_en;
  assign trg_o      = trg_q;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_o,
  input logic             upd_flag_o,
  input logic             irq_o,
  input logic             trg_o,
  input logic             upd_ev_i,
  input logic             force_upd_i,
  input logic             level_i,
  input logic [2:0]       sm_i,
  input logic [2:0]       mm_i
);
  assert_upd_sets_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_ev_i |=> upd_flag_o);

  assert_irq_needs_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> upd_flag_o);

  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_o) |-> (cnt_o == '0) || (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));

  assert_gate_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sm_i == 3'd5 && !level_i && !force_upd_i) |=> $stable(cnt_o));

  assert_reserved_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sm_i inside {3'd1, 3'd2, 3'd3} && !force_upd_i) |=> $stable(cnt_o));

  assert_update_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_ev_i && mm_i == 3'd2) |=> trg_o);
endmodule

bind slave_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cnt_o      (cnt_o),
  .upd_flag_o (upd_flag_o),
  .irq_o      (irq_o),
  .trg_o      (trg_o),
  .upd_ev_i   (upd_ev),
  .force_upd_i(force_upd),
  .level_i    (trig_level),
  .sm_i       (sm_q),
  .mm_i       (mm_q)
);

// File: tb/slave_timer_tb_top.sv
`timescale 1ns/1ps
module slave_timer_tb_top;
  localparam int CW = 16;
  localparam int NT = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [NT-1:0] trig = '0;
  logic [CW-1:0] cnt;
  logic          flag, irq, trg;
  int            checks = 0;
  int            errors = 0;

  always #2 clk = ~clk;

  slave_timer #(.CNT_W(CW), .N_TRIG(NT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .trig_i(trig), .cnt_o(cnt), .upd_flag_o(flag),
    .irq_o(irq), .trg_o(trg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic t_reset();
    chk("R1 count", cnt, 0);
    chk("R1 flag", flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 trg", trg, 0);
  endtask

  task automatic t_freerun();
    wr(3'd1, 16'h0020);
    wr(3'd3, 16'd4);
    wr(3'd0, 16'd1);
    chk("R2 start", cnt, 0);
    for (int i = 1; i <= 5; i++) begin
      step(1);
      chk("R2 sequence", cnt, i % 5);
    end
    chk("R3 flag on wrap", flag, 1);
    chk("R10 pulse on wrap", trg, 1);
    step(1);
    chk("R10 pulse width", trg, 0);
    chk("R2 after wrap", cnt, 1);
    chk("R3 irq disabled", irq, 0);
    wr(3'd0, 16'd4);
    chk("R3 irq enabled", irq, 1);
    wr(3'd4, 16'd0);
    chk("R3 flag cleared", flag, 0);
    chk("R3 irq cleared", irq, 0);
  endtask

  task automatic t_prescale();
    wr(3'd0, 16'd0);
    wr(3'd2, 16'd2);
    wr(3'd5, 16'd1);
    chk("R4 forced clears count", cnt, 0);
    chk("R4 forced sets flag", flag, 1);
    wr(3'd4, 16'd0);
    wr(3'd0, 16'd1);
    step(2);
    chk("R2 prescale hold", cnt, 0);
    step(1);
    chk("R2 prescale first", cnt, 1);
    step(3);
    chk("R2 prescale second", cnt, 2);
  endtask

  task automatic t_preload();
    wr(3'd0, 16'd0);
    wr(3'd2, 16'd0);
    wr(3'd5, 16'd1);
    wr(3'd0, 16'd2);
    wr(3'd3, 16'd2);
    wr(3'd0, 16'd3);
    step(3);
    chk("R4 old reload kept", cnt, 3);
    step(2);
    chk("R4 wrap at old reload", cnt, 0);
    step(3);
    chk("R4 new reload active", cnt, 0);
    wr(3'd0, 16'd0);
    wr(3'd4, 16'd0);
  endtask

  task automatic t_reset_mode();
    wr(3'd3, 16'd100);
    wr(3'd1, 16'h0004);
    wr(3'd5, 16'd1);
    wr(3'd4, 16'd0);
    wr(3'd0, 16'd1);
    step(10);
    chk("R5 running", cnt, 10);
    trig[0] = 1'b1;
    step(2);
    chk("R5 sync delay", cnt, 12);
    step(1);
    chk("R5 restart", cnt, 0);
    chk("R5 update flag", flag, 1);
    chk("R10 reset-update pulse", trg, 1);
    step(1);
    chk("R5 counts on", cnt, 1);
    wr(3'd4, 16'd0);
    trig[0] = 1'b0;
    step(3);
    trig[0] = 1'b1;
    step(2);
    wr(3'd4, 16'd0);
    chk("R3 set wins over clear", flag, 1);
    chk("R5 second restart", cnt, 0);
    trig[0] = 1'b0;
    step(3);
  endtask

  task automatic t_gated();
    wr(3'd0, 16'd0);
    wr(3'd1, 16'h0005);
    wr(3'd5, 16'd1);
    wr(3'd4, 16'd0);
    wr(3'd0, 16'd1);
    step(5);
    chk("R6 low holds", cnt, 0);
    trig[0] = 1'b1;
    step(2);
    chk("R6 sync delay", cnt, 0);
    step(1);
    chk("R6 high counts", cnt, 1);
    step(4);
    chk("R6 high counts on", cnt, 5);
    trig[0] = 1'b0;
    step(2);
    chk("R6 stop after delay", cnt, 7);
    step(5);
    chk("R6 hold not cleared", cnt, 7);
  endtask

  task automatic t_start();
    wr(3'd0, 16'd0);
    wr(3'd1, 16'h0016);
    wr(3'd5, 16'd1);
    wr(3'd4, 16'd0);
    step(4);
    chk("R7 idle", cnt, 0);
    chk("R10 enable level low", trg, 0);
    trig[0] = 1'b1;
    step(3);
    chk("R7 enable just set", cnt, 0);
    step(1);
    chk("R7 started", cnt, 1);
    chk("R10 enable level high", trg, 1);
    trig[0] = 1'b0;
    step(5);
    chk("R7 falling edge ignored", cnt, 6);
  endtask

  task automatic pulse(input int idx);
    trig[idx] = 1'b1; step(2);
    trig[idx] = 1'b0; step(2);
  endtask

  task automatic t_extclk();
    wr(3'd0, 16'd0);
    wr(3'd1, 16'h0107);
    wr(3'd5, 16'd1);
    wr(3'd4, 16'd0);
    wr(3'd0, 16'd1);
    step(3);
    chk("R8 no edges", cnt, 0);
    for (int i = 0; i < 3; i++) pulse(1);
    step(3);
    chk("R8 one per edge", cnt, 3);
    for (int i = 0; i < 3; i++) pulse(0);
    step(3);
    chk("R9 unselected ignored", cnt, 3);
    wr(3'd1, 16'h0007);
    pulse(0);
    step(3);
    chk("R9 new source", cnt, 4);
  endtask

  task automatic t_reserved();
    logic [CW-1:0] c;
    wr(3'd1, 16'h0002);
    c = cnt;
    step(5);
    chk("R11 code 2 holds", cnt, c);
    wr(3'd1, 16'h0001);
    step(4);
    chk("R11 code 1 holds", cnt, c);
    wr(3'd1, 16'h0003);
    step(4);
    chk("R11 code 3 holds", cnt, c);
    wr(3'd1, 16'h0000);
    step(1);
    chk("R11 normal resumes", cnt, c + 1);
  endtask

  task automatic t_master();
    int seen;
    wr(3'd0, 16'd0);
    wr(3'd3, 16'd2);
    wr(3'd1, 16'h0000);
    wr(3'd5, 16'd1);
    wr(3'd0, 16'd1);
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      step(1);
      if (trg) seen++;
    end
    chk("R10 no pulse on wrap in code 0", seen, 0);
    wr(3'd5, 16'd1);
    chk("R10 pulse on forced update", trg, 1);
    wr(3'd1, 16'h0030);
    wr(3'd5, 16'd1);
    chk("R10 other code low", trg, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_freerun();
    t_prescale();
    t_preload();
    t_reset_mode();
    t_gated();
    t_start();
    t_extclk();
    t_reserved();
    t_master();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule